// File: doc/BRIEF.md
# Selectable-Clock 24-Bit Interval Timer

This block counts strobes from one of four clock-enable sources and raises an interrupt pulse each time a programmed 24-bit terminal count is reached. Software can program it in two ways. The first is a byte-wide register port: control, source select, and three count bytes. The second is a millisecond request path, which converts a delay into a terminal count for the chosen source. The request path checks that the source code is supported, that the count fits in 24 bits and that the count is not zero. Only if all three checks pass does it program the timer.

The counter starts at zero and advances by one on each strobe of the selected source. When it reaches the terminal count, it returns to zero and `irq_o` goes high for one cycle, which gives a rising edge to the interrupt controller. While the timer is stopped, the counter is held at zero. A successful millisecond request stops the timer, clears the counter, drops any interrupt due in the same cycle, and then starts the timer again only if a start was requested.

Top module: `sel_clk_timer`

## Requirements
- R1: After reset, `irq_o` is 0, `err_o` is 0, the timer is stopped, the terminal count is 0 and source 0 is selected.
- R2: While running, each strobe on the selected source (`tick_i[sel]`) advances the counter. The strobe that brings it to the terminal count N returns it to 0, and `irq_o` is high for the one cycle after that strobe's clock edge. With sparse strobes this gives one pulse every N strobes.
- R3: Strobes on sources other than the selected one do not change the counter.
- R4: Control register (address 0) bit 0 is run. While run is 0 the counter is held at 0, no interrupt is produced and strobes are ignored. After run is set again, counting restarts from 0.
- R5: Control register bit 1 is the interrupt enable. When it is 0, `irq_o` stays low while counting and wrapping carry on unchanged.
- R6: Address 1 bits 1:0 select the source. Addresses 2, 3 and 4 write count bits 7:0, 15:8 and 23:16.
- R7: Millisecond source codes 0, 1, 2 and 3 mean 32768 Hz, 1024 Hz, 32 Hz and 8 MHz. For codes 0 to 2 the count is freq × ms / 1000, truncated. For code 3 the count is 8000 × ms.
- R8: A source code of 4 to 7 gives `err_o` = 1 and leaves the timer unchanged.
- R9: A computed count of 2^24 or more gives `err_o` = 2 and leaves the timer unchanged.
- R10: A computed count of 0 gives `err_o` = 3 and leaves the timer unchanged.
- R11: An accepted request gives `err_o` = 0. It loads the count and source, clears the counter, sets run and interrupt enable from `ms_run_i` and `ms_irq_en_i`, and drops an interrupt that a strobe in the same cycle would have raised. If a request and a register write arrive in the same cycle, the request takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 4 | Clock-enable strobes, one per source |
| ms_req_i | input | 1 | Millisecond programming request (one cycle) |
| ms_src_i | input | 3 | Requested source code |
| ms_val_i | input | 16 | Requested delay in milliseconds |
| ms_run_i | input | 1 | Start the timer after programming |
| ms_irq_en_i | input | 1 | Interrupt enable to program |
| irq_o | output | 1 | Interrupt pulse |
| err_o | output | 2 | Result of the last millisecond request |

## Verification
The bench builds the block with its defaults: a 24-bit count, a 16-bit millisecond input and a 3-bit request source code. With these values the whole high byte is within reach. One run holds a strobe for 65539 cycles to reach a terminal count of 0x010003. The 8 MHz overflow edge is reached exactly: 2097 ms gives 16,776,000 and is accepted, while 2098 ms gives 16,784,000 and is rejected. Truncation is also reached at its edge, since 32 Hz × 31 ms rounds down to a count of zero.

// File: rtl/sel_clk_timer_pkg.sv
package sel_clk_timer_pkg;
  localparam int unsigned N_SRC    = 4;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned SRC_OFS  = 1;
  localparam int unsigned CNT_OFS  = 2;
  // frequency = 2**shift for the slow sources
  localparam int unsigned SH_32K   = 15;
  localparam int unsigned SH_1K    = 10;
  localparam int unsigned SH_32    = 5;
  localparam int unsigned FAST_KHZ = 8000;
  localparam int unsigned MS_DIV   = 1000;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_SRC   = 2'd1,
    ERR_RANGE = 2'd2,
    ERR_ZERO  = 2'd3
  } conv_err_e;

  typedef struct packed {
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/sel_clk_timer_conv.sv
module sel_clk_timer_conv
  import sel_clk_timer_pkg::*;
#(
  parameter int unsigned MS_W  = 16,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned RSRC_W = 3
) (
  input  logic [RSRC_W-1:0] src_i,
  input  logic [MS_W-1:0]   ms_i,
  output logic [CNT_W-1:0]  count_o,
  output conv_err_e         err_o
);
  localparam int unsigned PW = MS_W + 16;

  logic [PW-1:0] full;

  always_comb begin
    full  = '0;
    err_o = ERR_NONE;
    case (src_i)
      RSRC_W'(0): full = (PW'(ms_i) << SH_32K) / PW'(MS_DIV);
      RSRC_W'(1): full = (PW'(ms_i) << SH_1K) / PW'(MS_DIV);
      RSRC_W'(2): full = (PW'(ms_i) << SH_32) / PW'(MS_DIV);
      RSRC_W'(3): full = PW'(ms_i) * PW'(FAST_KHZ);
      default:    err_o = ERR_SRC;
    endcase
    if (err_o == ERR_NONE) begin
      if ((full >> CNT_W) != '0) err_o = ERR_RANGE;
      else if (full == '0)       err_o = ERR_ZERO;
    end
  end

  assign count_o = full[CNT_W-1:0];
endmodule

// File: rtl/sel_clk_timer_regs.sv
module sel_clk_timer_regs
  import sel_clk_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              prog_i,
  input  logic [CNT_W-1:0]  prog_cnt_i,
  input  logic [SEL_W-1:0]  prog_src_i,
  input  logic              prog_run_i,
  input  logic              prog_ie_i,
  output logic [CNT_W-1:0]  term_o,
  output logic [SEL_W-1:0]  src_o,
  output logic              run_o,
  output logic              ie_o
);
  localparam int unsigned NB = CNT_W / 8;

  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= '0;
    end else if (prog_i) begin
      ctrl_q <= '{irq_en: prog_ie_i, run: prog_run_i};
      src_q  <= prog_src_i;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(CTRL_OFS)) ctrl_q <= ctrl_t'(wr_data_i[1:0]);
      if (wr_addr_i == ADDR_W'(SRC_OFS))  src_q  <= wr_data_i[SEL_W-1:0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [ADDR_W-1:0] BA = ADDR_W'(CNT_OFS + b);
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          byte_q <= '0;
      else if (prog_i)                      byte_q <= prog_cnt_i[b*8 +: 8];
      else if (wr_en_i && wr_addr_i == BA)  byte_q <= wr_data_i;
    end
    assign term_o[b*8 +: 8] = byte_q;
  end

  assign src_o = src_q;
  assign run_o = ctrl_q.run;
  assign ie_o  = ctrl_q.irq_en;
endmodule

// File: rtl/sel_clk_timer_counter.sv
module sel_clk_timer_counter
  import sel_clk_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] src_i,
  input  logic             run_i,
  input  logic             ie_i,
  input  logic [CNT_W-1:0] term_i,
  input  logic             clr_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             sel_tick, hit, irq_q;

  assign sel_tick = tick_i[src_i];
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign hit      = run_i && sel_tick && (cnt_inc == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit && ie_i && !clr_i;
      if (clr_i || !run_i) cnt_q <= '0;
      else if (sel_tick)   cnt_q <= hit ? '0 : cnt_inc;
    end
  end

  assign irq_o = irq_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/sel_clk_timer.sv
module sel_clk_timer
  import sel_clk_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned MS_W   = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned RSRC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [N_SRC-1:0]  tick_i,
  input  logic              ms_req_i,
  input  logic [RSRC_W-1:0] ms_src_i,
  input  logic [MS_W-1:0]   ms_val_i,
  input  logic              ms_run_i,
  input  logic              ms_irq_en_i,
  output logic              irq_o,
  output logic [1:0]        err_o
);
  localparam int unsigned SEL_W = $clog2(N_SRC);

  logic [CNT_W-1:0] conv_cnt_w, term_w, cnt_w;
  conv_err_e        conv_err_w, err_q;
  logic [SEL_W-1:0] src_w;
  logic             run_w, ie_w, prog_w;

  sel_clk_timer_conv #(.MS_W(MS_W), .CNT_W(CNT_W), .RSRC_W(RSRC_W)) u_conv (
    .src_i   (ms_src_i),
    .ms_i    (ms_val_i),
    .count_o (conv_cnt_w),
    .err_o   (conv_err_w)
  );

  assign prog_w = ms_req_i && (conv_err_w == ERR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= ERR_NONE;
    else if (ms_req_i) err_q <= conv_err_w;
  end

  sel_clk_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .prog_i     (prog_w),
    .prog_cnt_i (conv_cnt_w),
    .prog_src_i (ms_src_i[SEL_W-1:0]),
    .prog_run_i (ms_run_i),
    .prog_ie_i  (ms_irq_en_i),
    .term_o     (term_w),
    .src_o      (src_w),
    .run_o      (run_w),
    .ie_o       (ie_w)
  );

  sel_clk_timer_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .src_i  (src_w),
    .run_i  (run_w),
    .ie_i   (ie_w),
    .term_i (term_w),
    .clr_i  (prog_w),
    .irq_o  (irq_o),
    .cnt_o  (cnt_w)
  );

  assign err_o = err_q;
endmodule

// File: rtl/sel_clk_timer_chk.sv
module sel_clk_timer_chk
  import sel_clk_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [N_SRC-1:0] tick_i,
  input logic             ms_req_i,
  input logic             irq_o,
  input logic [1:0]       err_o,
  input logic [1:0]       conv_err,
  input logic [CNT_W-1:0] term,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] src,
  input logic             run,
  input logic             ie
);
  // R1
  initial_idle_chk: assert property (@(posedge clk_i) !rst_ni |=> !irq_o || !rst_ni);

  // R2
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(run && tick_i[src]));

  // R3
  unselected_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !tick_i[src] && !ms_req_i |=> cnt == $past(cnt));

  // R4
  stopped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> cnt == '0);

  // R5
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ie));

  // R8 R9 R10
  reject_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_req_i && conv_err != 2'd0 && !wr_en_i |=> $stable(term) && err_o == $past(conv_err));

  // R11
  accept_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_req_i && conv_err == 2'd0 |=> cnt == '0 && !irq_o && err_o == 2'd0);
endmodule

bind sel_clk_timer sel_clk_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .tick_i   (tick_i),
  .ms_req_i (ms_req_i),
  .irq_o    (irq_o),
  .err_o    (err_o),
  .conv_err (conv_err_w),
  .term     (term_w),
  .cnt      (cnt_w),
  .src      (src_w),
  .run      (run_w),
  .ie       (ie_w)
);

// File: tb/tb_sel_clk_timer.sv
module tb_sel_clk_timer;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  tick = '0;
  logic        ms_req = 1'b0, ms_run = 1'b0, ms_ie = 1'b0;
  logic [2:0]  ms_src = '0;
  logic [15:0] ms_val = '0;
  logic        irq;
  logic [1:0]  err;

  int errors = 0, checks = 0, irq_cnt = 0;
  string cur_req = "R1";

  sel_clk_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tick_i(tick), .ms_req_i(ms_req), .ms_src_i(ms_src), .ms_val_i(ms_val),
    .ms_run_i(ms_run), .ms_irq_en_i(ms_ie), .irq_o(irq), .err_o(err)
  );

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int conv_ref(int s, longint ms, output longint c);
    c = 0;
    case (s)
      0: c = (32768 * ms) / 1000;
      1: c = (1024 * ms) / 1000;
      2: c = (32 * ms) / 1000;
      3: c = 8000 * ms;
      default: return 1;
    endcase
    if (c >= 64'd16777216) return 2;
    if (c == 0) return 3;
    return 0;
  endfunction

  // behavioural reference
  longint m_cnt, m_term, pc;
  int m_src, m_err, pe;
  bit m_run, m_ie, m_irq, ok_prog, sel, hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_term = 0; m_src = 0; m_run = 0; m_ie = 0; m_irq = 0; m_err = 0;
    end else begin
      ok_prog = 0;
      if (ms_req) begin
        pe = conv_ref(int'(ms_src), longint'(ms_val), pc);
        m_err = pe;
        ok_prog = (pe == 0);
      end
      sel = tick[m_src];
      hit = m_run && sel && (((m_cnt + 1) % 64'd16777216) == m_term);
      m_irq = hit && m_ie && !ok_prog;
      if (ok_prog || !m_run) m_cnt = 0;
      else if (sel) m_cnt = hit ? 0 : m_cnt + 1;
      if (ok_prog) begin
        m_term = pc; m_src = int'(ms_src[1:0]); m_run = ms_run; m_ie = ms_ie;
      end else if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_run = wr_data[0]; m_ie = wr_data[1]; end
          3'd1: m_src = int'(wr_data[1:0]);
          3'd2: m_term = (m_term & 64'hFFFF00) | longint'(wr_data);
          3'd3: m_term = (m_term & 64'hFF00FF) | (longint'(wr_data) << 8);
          3'd4: m_term = (m_term & 64'h00FFFF) | (longint'(wr_data) << 16);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq === m_irq, {cur_req, " irq"}, longint'(irq), longint'(m_irq));
      chk(err === 2'(m_err), {cur_req, " err"}, longint'(err), longint'(m_err));
      if (irq === 1'b1) irq_cnt++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick[idx] = 1'b1;
      @(negedge clk); tick = '0;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic hold(input int idx, input int n);
    @(negedge clk); tick[idx] = 1'b1;
    repeat (n) @(negedge clk);
    tick = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic msreq(input logic [2:0] s, input logic [15:0] v, input bit r, input bit ie);
    @(negedge clk); ms_req = 1'b1; ms_src = s; ms_val = v; ms_run = r; ms_ie = ie;
    @(negedge clk); ms_req = 1'b0;
  endtask

  task automatic expect_irqs(input int base, input int n, input string req);
    chk(irq_cnt - base == n, req, longint'(irq_cnt - base), longint'(n));
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1", longint'(irq), 0);
    chk(err == 2'd0, "R1", longint'(err), 0);

    // R2 / R6: term 5 on source 1
    cur_req = "R2";
    wr(3'd1, 8'd1); wr(3'd2, 8'd5); wr(3'd3, 8'd0); wr(3'd4, 8'd0); wr(3'd0, 8'd3);
    b = irq_cnt; pulse(1, 12); expect_irqs(b, 2, "R2");

    // R3: other sources ignored; counter at 2, three more selected strobes fire
    cur_req = "R3";
    b = irq_cnt; pulse(0, 20); pulse(2, 20); pulse(3, 20); expect_irqs(b, 0, "R3");
    b = irq_cnt; pulse(1, 3); expect_irqs(b, 1, "R3");

    // R4: stopped timer ignores strobes and restarts from zero
    cur_req = "R4";
    wr(3'd0, 8'd2);
    b = irq_cnt; pulse(1, 10); expect_irqs(b, 0, "R4");
    wr(3'd0, 8'd3);
    b = irq_cnt; pulse(1, 4); expect_irqs(b, 0, "R4");
    pulse(1, 1); expect_irqs(b, 1, "R4");

    // R5: interrupt disabled, counting continues
    cur_req = "R5";
    wr(3'd0, 8'd1);
    b = irq_cnt; pulse(1, 10); expect_irqs(b, 0, "R5");
    wr(3'd0, 8'd3);
    pulse(1, 5); expect_irqs(b, 1, "R5");

    // R6: middle and high count bytes
    cur_req = "R6";
    wr(3'd2, 8'd3); wr(3'd3, 8'd1);
    b = irq_cnt; hold(1, 258); expect_irqs(b, 0, "R6");
    hold(1, 1); expect_irqs(b, 1, "R6");
    wr(3'd3, 8'd0); wr(3'd4, 8'd1);
    b = irq_cnt; hold(1, 65539); expect_irqs(b, 1, "R6");

    // R7 / R11: 1024 Hz x 10 ms -> 10 (truncated)
    cur_req = "R11";
    msreq(3'd1, 16'd10, 1'b1, 1'b1);
    chk(err == 2'd0, "R11", longint'(err), 0);
    // R8: unsupported source leaves the timer alone
    cur_req = "R8";
    msreq(3'd5, 16'd10, 1'b0, 1'b0);
    chk(err == 2'd1, "R8", longint'(err), 1);
    cur_req = "R7";
    b = irq_cnt; pulse(1, 9); expect_irqs(b, 0, "R7");
    pulse(1, 1); expect_irqs(b, 1, "R7");

    // R10: 32 Hz x 31 ms truncates to zero
    cur_req = "R10";
    msreq(3'd2, 16'd31, 1'b1, 1'b1);
    chk(err == 2'd3, "R10", longint'(err), 3);
    msreq(3'd0, 16'd0, 1'b1, 1'b1);
    chk(err == 2'd3, "R10", longint'(err), 3);

    // R9: 8 MHz overflow edge
    cur_req = "R9";
    msreq(3'd3, 16'd2098, 1'b1, 1'b1);
    chk(err == 2'd2, "R9", longint'(err), 2);
    msreq(3'd3, 16'd2097, 1'b0, 1'b1);
    chk(err == 2'd0, "R9", longint'(err), 0);
    b = irq_cnt; pulse(3, 5); expect_irqs(b, 0, "R11");

    // R7: 32768 Hz x 512 ms -> 16777
    cur_req = "R7";
    msreq(3'd0, 16'd512, 1'b1, 1'b1);
    b = irq_cnt; hold(0, 16776); expect_irqs(b, 0, "R7");
    hold(0, 1); expect_irqs(b, 1, "R7");

    // R11: request in the same cycle as a hit drops that interrupt
    cur_req = "R11";
    msreq(3'd1, 16'd2, 1'b1, 1'b1);
    pulse(1, 1);
    @(negedge clk);
    b = irq_cnt;
    tick[1] = 1'b1; ms_req = 1'b1; ms_src = 3'd1; ms_val = 16'd2; ms_run = 1'b1; ms_ie = 1'b1;
    @(negedge clk); tick = '0; ms_req = 1'b0;
    repeat (2) @(negedge clk);
    expect_irqs(b, 0, "R11");
    pulse(1, 2); expect_irqs(b, 1, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule